// File: doc/BRIEF.md
# I/O Port Lockout Gate

This block sits between the CPU's I/O cycles and the system bus. It gives a kernel a way to shut user code out of every I/O port. The kernel arms the lockout with a plain read of a dedicated arm port. From the next cycle on, any I/O cycle the CPU issues is kept off the bus and becomes a request for a non-maskable interrupt. The one exception is a read of the system-call port, which still reaches the bus so that the fault unit can handle it.

The lockout clears itself when the CPU enters kernel code. The block watches the CPU's interrupt-acknowledge indication and the vector number delivered with it. Only the NMI vector or the memory-fault vector releases the lockout, so no software write is needed to disarm it. The NMI request is a one-cycle pulse. At most one pulse goes out per armed period, so a burst of violating cycles gives the handler a single interrupt.

Top module: `io_port_lockout`

## Requirements
- R1: After reset the lockout is disarmed. Every I/O cycle is forwarded (`bus_io_req` follows `cpu_io_req`), `cpu_io_blocked` is low and `nmi_req` is low.
- R2: A read (`cpu_io_wr`=0) of the arm port 0x8A00 while disarmed is forwarded, raises no NMI, and arms the lockout from the next cycle.
- R3: A write to the arm port 0x8A00 does not arm the lockout; later cycles are still forwarded.
- R4: While armed, an I/O cycle that is not a system-call read is suppressed in the same cycle: `bus_io_req` is low and `cpu_io_blocked` is high.
- R5: A suppressed cycle drives `nmi_req` high for exactly one clock, in the cycle after the violating access.
- R6: After one NMI pulse, later violations in the same armed period are still suppressed but raise no further pulse until the lockout is released.
- R7: While armed, a read of the system-call port 0x8800 is forwarded and raises no NMI. A write to 0x8800 while armed counts as a violation.
- R8: An access to the control port 0x8000 while armed is a violation (suppressed, NMI pulse).
- R9: An acknowledge (`inta_valid`=1) carrying vector 0x02 (NMI) releases the lockout from the next cycle.
- R10: An acknowledge carrying vector 0x20 (memory fault) releases the lockout. An acknowledge with any other vector leaves it armed.
- R11: When an arm-port read and a releasing acknowledge fall in the same cycle, the release wins and the lockout stays disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_io_req | input | 1 | CPU I/O cycle strobe, one cycle per access |
| cpu_io_wr | input | 1 | 1 = I/O write, 0 = I/O read |
| cpu_io_addr | input | 16 | I/O port address |
| inta_valid | input | 1 | CPU is fetching an interrupt vector this cycle |
| inta_vector | input | 8 | Vector number being fetched |
| bus_io_req | output | 1 | Forwarded I/O strobe to the system bus |
| bus_io_wr | output | 1 | Forwarded direction |
| bus_io_addr | output | 16 | Forwarded address |
| cpu_io_blocked | output | 1 | Current CPU cycle is being suppressed |
| nmi_req | output | 1 | One-cycle NMI request pulse |

## Verification
On every cycle the assertions check three things: the gating is right for the current lock state, every NMI pulse follows a suppressed cycle and lasts one clock, and an arm read or a releasing acknowledge moves the lock state one cycle later. The bench scenarios show the effects that play out over a sequence of cycles. These are the single pulse per armed period, a write to the arm port having no effect, acknowledges with other vectors leaving the lock in place, and the priority of release over arming in the same cycle.

// File: rtl/io_lock_pkg.sv
package io_lock_pkg;
    parameter int ADDR_W = 16;
    parameter int VEC_W  = 8;

    typedef struct packed {
        logic armed;
        logic nmi_sent;
        logic nmi;
    } lock_state_t;
endpackage

// File: rtl/io_lock_decode.sv
module io_lock_decode #(
    parameter int                 ADDR_W       = 16,
    parameter int                 VEC_W        = 8,
    parameter logic [ADDR_W-1:0]  ARM_PORT     = 16'h8A00,
    parameter logic [ADDR_W-1:0]  SYSCALL_PORT = 16'h8800,
    parameter logic [VEC_W-1:0]   NMI_VEC      = 8'h02,
    parameter logic [VEC_W-1:0]   FAULT_VEC    = 8'h20
) (
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  ack_vector,
    output logic              arm_read,
    output logic              exempt_read,
    output logic              release_hit
);
    always_comb begin
        arm_read    = io_req && !io_wr && (io_addr == ARM_PORT);
        exempt_read = io_req && !io_wr && (io_addr == SYSCALL_PORT);
        release_hit = ack_valid && ((ack_vector == NMI_VEC) || (ack_vector == FAULT_VEC));
    end
endmodule

// File: rtl/io_lock_state.sv
module io_lock_state
    import io_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_read,
    input  logic violation,
    input  logic release_hit,
    output logic armed,
    output logic nmi_pulse
);
    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // one pulse per armed period
        st_d.nmi = violation && !st_q.nmi_sent;
        if (release_hit) begin
            st_d.armed    = 1'b0;
            st_d.nmi_sent = 1'b0;
        end else begin
            if (arm_read && !st_q.armed)
                st_d.armed = 1'b1;
            if (violation)
                st_d.nmi_sent = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign armed     = st_q.armed;
    assign nmi_pulse = st_q.nmi;
endmodule

// File: rtl/io_lock_gate.sv
module io_lock_gate #(
    parameter int ADDR_W = 16
) (
    input  logic              armed,
    input  logic              exempt_read,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              fwd_req,
    output logic              fwd_wr,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              violation
);
    always_comb begin
        violation = io_req && armed && !exempt_read;
        fwd_req   = io_req && !violation;
        fwd_wr    = io_wr;
        fwd_addr  = io_addr;
    end
endmodule

// File: rtl/io_port_lockout.sv
module io_port_lockout
    import io_lock_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ARM_PORT     = 16'h8A00,
    parameter logic [ADDR_W-1:0] SYSCALL_PORT = 16'h8800,
    parameter logic [VEC_W-1:0]  NMI_VEC      = 8'h02,
    parameter logic [VEC_W-1:0]  FAULT_VEC    = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_io_req,
    input  logic              cpu_io_wr,
    input  logic [ADDR_W-1:0] cpu_io_addr,
    input  logic              inta_valid,
    input  logic [VEC_W-1:0]  inta_vector,
    output logic              bus_io_req,
    output logic              bus_io_wr,
    output logic [ADDR_W-1:0] bus_io_addr,
    output logic              cpu_io_blocked,
    output logic              nmi_req
);
    logic arm_read, exempt_read, release_hit, violation, lock_armed;

    io_lock_decode #(
        .ADDR_W(ADDR_W), .VEC_W(VEC_W), .ARM_PORT(ARM_PORT),
        .SYSCALL_PORT(SYSCALL_PORT), .NMI_VEC(NMI_VEC), .FAULT_VEC(FAULT_VEC)
    ) dec_i (
        .io_req(cpu_io_req), .io_wr(cpu_io_wr), .io_addr(cpu_io_addr),
        .ack_valid(inta_valid), .ack_vector(inta_vector),
        .arm_read(arm_read), .exempt_read(exempt_read), .release_hit(release_hit)
    );

    io_lock_gate #(.ADDR_W(ADDR_W)) gate_i (
        .armed(lock_armed), .exempt_read(exempt_read),
        .io_req(cpu_io_req), .io_wr(cpu_io_wr), .io_addr(cpu_io_addr),
        .fwd_req(bus_io_req), .fwd_wr(bus_io_wr), .fwd_addr(bus_io_addr),
        .violation(violation)
    );

    io_lock_state st_i (
        .clk(clk), .rst_n(rst_n), .arm_read(arm_read), .violation(violation),
        .release_hit(release_hit), .armed(lock_armed), .nmi_pulse(nmi_req)
    );

    assign cpu_io_blocked = violation;
endmodule

// File: rtl/io_port_lockout_chk.sv
module io_port_lockout_chk
    import io_lock_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ARM_PORT     = 16'h8A00,
    parameter logic [ADDR_W-1:0] SYSCALL_PORT = 16'h8800,
    parameter logic [VEC_W-1:0]  NMI_VEC      = 8'h02,
    parameter logic [VEC_W-1:0]  FAULT_VEC    = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_io_req,
    input logic              cpu_io_wr,
    input logic [ADDR_W-1:0] cpu_io_addr,
    input logic              inta_valid,
    input logic [VEC_W-1:0]  inta_vector,
    input logic              bus_io_req,
    input logic              cpu_io_blocked,
    input logic              nmi_req,
    input logic              lock_armed
);
    logic sys_rd, rel;
    assign sys_rd = cpu_io_req && !cpu_io_wr && (cpu_io_addr == SYSCALL_PORT);
    assign rel    = inta_valid && (inta_vector == NMI_VEC || inta_vector == FAULT_VEC);

    p_pass_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_armed |-> (bus_io_req == cpu_io_req) && !cpu_io_blocked);

    p_arm_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_io_req && !cpu_io_wr && cpu_io_addr == ARM_PORT && !lock_armed && !rel)
        |=> lock_armed);

    p_block_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_armed && cpu_io_req && !sys_rd) |-> (!bus_io_req && cpu_io_blocked));

    p_nmi_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past(cpu_io_blocked));

    p_nmi_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    p_sys_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rd |-> bus_io_req);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> !lock_armed);
endmodule

bind io_port_lockout io_port_lockout_chk #(
    .ARM_PORT(ARM_PORT), .SYSCALL_PORT(SYSCALL_PORT),
    .NMI_VEC(NMI_VEC), .FAULT_VEC(FAULT_VEC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_io_req(cpu_io_req), .cpu_io_wr(cpu_io_wr),
    .cpu_io_addr(cpu_io_addr), .inta_valid(inta_valid), .inta_vector(inta_vector),
    .bus_io_req(bus_io_req), .cpu_io_blocked(cpu_io_blocked), .nmi_req(nmi_req),
    .lock_armed(lock_armed)
);

// File: tb/io_port_lockout_tb_top.sv
module io_port_lockout_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_io_req, cpu_io_wr, inta_valid;
    logic [15:0] cpu_io_addr;
    logic [7:0]  inta_vector;
    logic        bus_io_req, bus_io_wr, cpu_io_blocked, nmi_req;
    logic [15:0] bus_io_addr;

    int checks = 0;
    int fails  = 0;
    logic s_req, s_blk, s_nmi;

    always #2 clk = ~clk;

    io_port_lockout dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_io_req(cpu_io_req), .cpu_io_wr(cpu_io_wr),
        .cpu_io_addr(cpu_io_addr), .inta_valid(inta_valid), .inta_vector(inta_vector),
        .bus_io_req(bus_io_req), .bus_io_wr(bus_io_wr), .bus_io_addr(bus_io_addr),
        .cpu_io_blocked(cpu_io_blocked), .nmi_req(nmi_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, sample forwarding before the edge, NMI after it
    task automatic cyc(input bit req, input bit wr, input logic [15:0] addr,
                       input bit ack, input logic [7:0] vec);
        @(negedge clk);
        cpu_io_req = req; cpu_io_wr = wr; cpu_io_addr = addr;
        inta_valid = ack; inta_vector = vec;
        #1;
        s_req = bus_io_req; s_blk = cpu_io_blocked;
        @(posedge clk); #1;
        s_nmi = nmi_req;
    endtask

    task automatic idle();
        cyc(0, 0, 16'h0000, 0, 8'h00);
    endtask

    task automatic expect_io(input string tag, input bit req_e, input bit blk_e, input bit nmi_e);
        chk(s_req == req_e, {tag, " bus_io_req"}, s_req, req_e);
        chk(s_blk == blk_e, {tag, " blocked"}, s_blk, blk_e);
        chk(s_nmi == nmi_e, {tag, " nmi"}, s_nmi, nmi_e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cpu_io_req = 0; cpu_io_wr = 0; cpu_io_addr = 0; inta_valid = 0; inta_vector = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic arm();
        cyc(1, 0, 16'h8A00, 0, 8'h00);
    endtask

    task automatic t_reset_r1();
        do_reset();
        cyc(1, 1, 16'h1234, 0, 8'h00);
        expect_io("R1 idle write", 1, 0, 0);
        chk(bus_io_addr == 16'h1234 && bus_io_wr, "R1 fields", bus_io_addr, 16'h1234);
        cyc(1, 0, 16'h8000, 0, 8'h00);
        expect_io("R1 ctrl read", 1, 0, 0);
    endtask

    task automatic t_arm_r2_r4_r5();
        arm();
        expect_io("R2 arm read", 1, 0, 0);
        cyc(1, 0, 16'h0060, 0, 8'h00);
        expect_io("R4 armed read", 0, 1, 1);
        idle();
        chk(s_nmi == 0, "R5 pulse width", s_nmi, 0);
        cyc(0, 0, 16'h0000, 1, 8'h02);
    endtask

    task automatic t_arm_write_r3();
        cyc(1, 1, 16'h8A00, 0, 8'h00);
        expect_io("R3 arm write", 1, 0, 0);
        cyc(1, 1, 16'h0060, 0, 8'h00);
        expect_io("R3 not armed", 1, 0, 0);
    endtask

    task automatic t_single_r6();
        arm();
        cyc(1, 1, 16'h0040, 0, 8'h00);
        expect_io("R6 first", 0, 1, 1);
        cyc(1, 0, 16'h0041, 0, 8'h00);
        expect_io("R6 second", 0, 1, 0);
        cyc(1, 0, 16'h8A00, 0, 8'h00);
        expect_io("R6 rearm read", 0, 1, 0);
        cyc(0, 0, 16'h0000, 1, 8'h20);
        arm();
        cyc(1, 0, 16'h0041, 0, 8'h00);
        expect_io("R6 new period", 0, 1, 1);
        cyc(0, 0, 16'h0000, 1, 8'h02);
    endtask

    task automatic t_syscall_r7();
        arm();
        cyc(1, 0, 16'h8800, 0, 8'h00);
        expect_io("R7 syscall read", 1, 0, 0);
        cyc(1, 1, 16'h8800, 0, 8'h00);
        expect_io("R7 syscall write", 0, 1, 1);
        cyc(0, 0, 16'h0000, 1, 8'h02);
    endtask

    task automatic t_ctrl_r8();
        arm();
        cyc(1, 1, 16'h8000, 0, 8'h00);
        expect_io("R8 ctrl write", 0, 1, 1);
        cyc(0, 0, 16'h0000, 1, 8'h02);
    endtask

    task automatic t_release_nmi_r9();
        arm();
        cyc(0, 0, 16'h0000, 1, 8'h02);
        cyc(1, 0, 16'h0300, 0, 8'h00);
        expect_io("R9 after nmi ack", 1, 0, 0);
    endtask

    task automatic t_release_fault_r10();
        arm();
        cyc(0, 0, 16'h0000, 1, 8'h21);
        cyc(0, 0, 16'h0000, 1, 8'h08);
        cyc(1, 0, 16'h0300, 0, 8'h00);
        expect_io("R10 other vectors", 0, 1, 1);
        cyc(0, 0, 16'h0000, 1, 8'h20);
        cyc(1, 0, 16'h0300, 0, 8'h00);
        expect_io("R10 after fault ack", 1, 0, 0);
    endtask

    task automatic t_race_r11();
        cyc(1, 0, 16'h8A00, 1, 8'h20);
        expect_io("R11 arm+ack", 1, 0, 0);
        cyc(1, 0, 16'h0300, 0, 8'h00);
        expect_io("R11 still open", 1, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_arm_r2_r4_r5();
        t_arm_write_r3();
        t_single_r6();
        t_syscall_r7();
        t_ctrl_r8();
        t_release_nmi_r9();
        t_release_fault_r10();
        t_race_r11();
        do_reset();
        idle();
        chk(s_nmi == 0 && s_req == 0, "R1 reset idle", s_nmi, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule